// File: doc/BRIEF.md
# Serial Three-Bit Combination Lock

This block is the control for a keyed door that takes its code one bit at a time. For each bit, the operator sets a single key switch and presses an ENTER button. The block compares that bit with the matching bit of a stored combination. When all three bits have been entered, exactly one of two outputs rises. One output opens the lock and the other lights an error lamp. A reset button returns the block to its starting point from any state.

A wrong bit does not end the entry early. After a mismatch the machine moves onto a second chain of wait states that mirrors the good path. The error output therefore rises on the same clock edge, counted from the last press, on which the unlock output would have risen. An observer cannot tell from the timing which bit was wrong.

The combination is held in a register. While the machine sits in its start state, that register follows the `comboIn` pins. It freezes at the first ENTER press.

Top module: `serial_lock`

## Requirements
- R1: A high `rst` at a clock edge puts the block in its start state. `unlock` and `error` are then both low.
- R2: The block leaves the start state only on a rising edge of `enterBtn`. The key bit is sampled on the clock edge after each press. The first press is checked against `comboIn[0]`, the second against `comboIn[1]` and the third against `comboIn[2]`.
- R3: If all three bits match, `unlock` goes high on the second rising clock edge after the third ENTER rise.
- R4: If any bit mismatches, `error` goes high on that same second edge after the third press. Before the third press both outputs stay low.
- R5: Once `unlock` or `error` is high, it stays high, and further ENTER presses or key changes have no effect, until `rst`.
- R6: `unlock` and `error` are never high together.
- R7: ENTER held high over many cycles advances the entry by exactly one bit.
- R8: The combination is captured on the clock edge of the first ENTER press. Changes on `comboIn` after that have no effect on the current entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset button, active high |
| enterBtn | input | 1 | ENTER button level, active high |
| keyBit | input | 1 | Key switch bit for the current step |
| comboIn | input | 3 | Combination; bit 0 is checked first |
| unlock | output | 1 | High while the lock is open |
| error | output | 1 | High after a complete wrong entry |

## Verification
The assertions take for granted that `enterBtn`, `keyBit` and `comboIn` are synchronous to `clk`. They also assume that `keyBit` holds steady from the ENTER rise through the following clock edge, where it is sampled. The stimulus changes every input only at the falling clock edge. It sets the key bit before raising ENTER and keeps it there for two rising edges, so each comparison sees the intended bit. Moves to or from the comboIn pins and the held-button case are applied only between samples, so each check isolates one effect.

// File: rtl/lock_pkg.sv
package lock_pkg;
  localparam int KEY_LEN = 3;
  localparam int IDX_W = (KEY_LEN > 1) ? $clog2(KEY_LEN) : 1;

  typedef enum logic [2:0] {
    PH_START,
    PH_COMP,
    PH_WAIT,
    PH_BAD_WAIT,
    PH_BAD_STEP,
    PH_OPEN,
    PH_FAIL
  } phase_t;

  typedef struct packed {
    logic             loadCombo;
    logic             compareEn;
    logic [IDX_W-1:0] bitSel;
  } lock_strobe_t;
endpackage

// File: rtl/lock_datapath.sv
module lock_datapath
  import lock_pkg::*;
#(
  parameter int LEN = KEY_LEN
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           enterBtn,
  input  logic           keyBit,
  input  logic [LEN-1:0] comboIn,
  input  lock_strobe_t   st,
  output logic           enterPulse,
  output logic           keyMatch
);
  logic           enterPrev;
  logic [LEN-1:0] comboReg;

  always_ff @(posedge clk) begin
    if (rst) begin
      enterPrev <= 1'b0;
      comboReg  <= '0;
    end else begin
      enterPrev <= enterBtn;
      if (st.loadCombo) comboReg <= comboIn;
    end
  end

  assign enterPulse = enterBtn & ~enterPrev;
  assign keyMatch   = (keyBit == comboReg[st.bitSel]);
endmodule

// File: rtl/lock_control.sv
module lock_control
  import lock_pkg::*;
#(
  parameter int LEN = KEY_LEN
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         enterPulse,
  input  logic         keyMatch,
  output lock_strobe_t st,
  output logic         unlock,
  output logic         error
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(LEN - 1);

  phase_t           phase, phaseNext;
  logic [IDX_W-1:0] pos, posNext;

  always_ff @(posedge clk) begin
    if (rst) begin
      phase <= PH_START;
      pos   <= '0;
    end else begin
      phase <= phaseNext;
      pos   <= posNext;
    end
  end

  always_comb begin
    phaseNext = phase;
    posNext   = pos;
    unique case (phase)
      PH_START: if (enterPulse) begin
        phaseNext = PH_COMP;
        posNext   = '0;
      end
      PH_COMP: begin
        if (pos == LAST_IDX) phaseNext = keyMatch ? PH_OPEN : PH_FAIL;
        else                 phaseNext = keyMatch ? PH_WAIT : PH_BAD_WAIT;
      end
      PH_WAIT: if (enterPulse) begin
        phaseNext = PH_COMP;
        posNext   = pos + 1'b1;
      end
      PH_BAD_WAIT: if (enterPulse) begin
        phaseNext = PH_BAD_STEP;
        posNext   = pos + 1'b1;
      end
      PH_BAD_STEP: phaseNext = (pos == LAST_IDX) ? PH_FAIL : PH_BAD_WAIT;
      PH_OPEN:     phaseNext = PH_OPEN;
      PH_FAIL:     phaseNext = PH_FAIL;
      default:     phaseNext = PH_START;
    endcase
  end

  always_comb begin
    st.loadCombo = (phase == PH_START);
    st.compareEn = (phase == PH_COMP);
    st.bitSel    = pos;
  end

  assign unlock = (phase == PH_OPEN);
  assign error  = (phase == PH_FAIL);
endmodule

// File: rtl/serial_lock.sv
module serial_lock
  import lock_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic               enterBtn,
  input  logic               keyBit,
  input  logic [KEY_LEN-1:0] comboIn,
  output logic               unlock,
  output logic               error
);
  lock_strobe_t st;
  logic         enterPulse;
  logic         keyMatch;

  lock_datapath #(.LEN(KEY_LEN)) u_dp (
    .clk        (clk),
    .rst        (rst),
    .enterBtn   (enterBtn),
    .keyBit     (keyBit),
    .comboIn    (comboIn),
    .st         (st),
    .enterPulse (enterPulse),
    .keyMatch   (keyMatch)
  );

  lock_control #(.LEN(KEY_LEN)) u_ctrl (
    .clk        (clk),
    .rst        (rst),
    .enterPulse (enterPulse),
    .keyMatch   (keyMatch),
    .st         (st),
    .unlock     (unlock),
    .error      (error)
  );
endmodule

// File: rtl/lock_checker.sv
module lock_checker (
  input logic clk,
  input logic rst,
  input logic compareEn,
  input logic unlock,
  input logic error
);
  // R1: outputs low after a reset edge
  p_reset_quiet_r1: assert property (@(posedge clk) rst |=> (!unlock && !error));

  // R5: a result holds until reset
  p_open_hold_r5: assert property (@(posedge clk) disable iff (rst)
    unlock |=> unlock);
  p_fail_hold_r5: assert property (@(posedge clk) disable iff (rst)
    error |=> error);

  // R6: the two results are exclusive
  p_exclusive_r6: assert property (@(posedge clk) disable iff (rst)
    !(unlock && error));

  // R3: unlock rises only out of a comparison cycle
  p_open_after_cmp_r3: assert property (@(posedge clk) disable iff (rst)
    $rose(unlock) |-> $past(compareEn));
endmodule

bind serial_lock lock_checker u_chk (
  .clk       (clk),
  .rst       (rst),
  .compareEn (st.compareEn),
  .unlock    (unlock),
  .error     (error)
);

// File: tb/serial_lock_bench.sv
module serial_lock_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       enterBtn = 1'b0;
  logic       keyBit = 1'b0;
  logic [2:0] comboIn = 3'b000;
  logic       unlock, error;
  int         nChecks = 0;
  int         nFails = 0;

  always #10 clk = ~clk;

  serial_lock u_serial_lock (
    .clk(clk), .rst(rst), .enterBtn(enterBtn), .keyBit(keyBit),
    .comboIn(comboIn), .unlock(unlock), .error(error)
  );

  // {combo[2:0], key[2:0], expUnlock, expError}
  localparam int NVEC = 8;
  localparam logic [7:0] VECS [NVEC] = '{
    {3'b000, 3'b000, 2'b10},
    {3'b101, 3'b101, 2'b10},
    {3'b111, 3'b111, 2'b10},
    {3'b101, 3'b100, 2'b01},
    {3'b101, 3'b111, 2'b01},
    {3'b101, 3'b001, 2'b01},
    {3'b011, 3'b100, 2'b01},
    {3'b110, 3'b010, 2'b01}
  };

  task automatic check(input logic [1:0] act, input logic [1:0] exp, input string req);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: {unlock,error} actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic doReset();
    @(negedge clk);
    rst = 1'b1; enterBtn = 1'b0;
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
  endtask

  // Sets key, raises ENTER, holds through two rising edges, samples, releases.
  task automatic press(input logic k, input int holdExtra);
    keyBit = k;
    enterBtn = 1'b1;
    @(posedge clk);
    @(posedge clk);
    @(negedge clk);
    repeat (holdExtra) @(negedge clk);
    enterBtn = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    doReset();
    check({unlock, error}, 2'b00, "R1 reset state");

    for (int i = 0; i < NVEC; i++) begin
      doReset();
      comboIn = VECS[i][7:5];
      @(negedge clk);
      press(VECS[i][2], 0);
      press(VECS[i][3], 0);
      check({unlock, error}, 2'b00, "R4 no result before last bit");
      keyBit = VECS[i][4];
      enterBtn = 1'b1;
      @(posedge clk);
      @(negedge clk);
      check({unlock, error}, 2'b00, "R3/R4 not yet after one edge");
      @(posedge clk);
      @(negedge clk);
      check({unlock, error}, VECS[i][1:0], "R2 R3 R4 vector result");
      enterBtn = 1'b0;
      @(negedge clk);
    end

    // R7: a held button advances a single step
    doReset();
    comboIn = 3'b010;
    @(negedge clk);
    press(1'b0, 12);
    press(1'b1, 12);
    check({unlock, error}, 2'b00, "R7 held ENTER no extra steps");
    press(1'b0, 0);
    check({unlock, error}, 2'b10, "R7 held ENTER open after three");

    // R5: open holds against more presses
    press(1'b1, 0);
    press(1'b0, 0);
    repeat (5) @(negedge clk);
    check({unlock, error}, 2'b10, "R5 open holds");
    doReset();
    check({unlock, error}, 2'b00, "R1 reset from open");

    // R5: fail holds
    comboIn = 3'b000;
    @(negedge clk);
    press(1'b1, 0); press(1'b0, 0); press(1'b0, 0);
    check({unlock, error}, 2'b01, "R4 first bit wrong");
    press(1'b0, 0);
    check({unlock, error}, 2'b01, "R5 fail holds");

    // R8: combination frozen after first press
    doReset();
    comboIn = 3'b011;
    @(negedge clk);
    press(1'b1, 0);
    comboIn = 3'b100;
    press(1'b1, 0); press(1'b0, 0);
    check({unlock, error}, 2'b10, "R8 combo change ignored");

    // R1: reset mid-entry then fresh entry
    doReset();
    comboIn = 3'b001;
    @(negedge clk);
    press(1'b1, 0); press(1'b1, 0);
    doReset();
    check({unlock, error}, 2'b00, "R1 reset mid-entry");
    press(1'b1, 0); press(1'b0, 0); press(1'b0, 0);
    check({unlock, error}, 2'b10, "R1 fresh entry after reset");

    // R2: no press, no progress
    doReset();
    keyBit = 1'b1;
    repeat (20) @(negedge clk);
    check({unlock, error}, 2'b00, "R2 idle without ENTER");

    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    nFails++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end
endmodule